// File: doc/BRIEF.md
# Edge-Counting Pulse Accumulator with Overflow Flag

This block counts rising edges on an asynchronous input pin. It can run as one 16-bit counter or as an 8-bit counter that uses only the low byte of the count. An overflow flag records when the active counter wraps around. In 8-bit mode, a ceiling option can hold the low byte at its maximum value. While the ceiling holds it there, each further edge raises the flag again instead of wrapping the count.

Software uses a small register bus with two addresses. Address 0 is the status register, which holds the flag. Address 1 is the count, which can be read and written. There are two ways to clear the flag, and only one is active at a time:

- **Write-one-to-clear:** writing 1 to the flag bit of the status register clears it.
- **Fast clear:** when fast clear is enabled, any access to the count register clears the flag. In this mode, writes to the status register no longer clear it.

An enable input must be high for edges to be counted.

Top module: `pacc_ovf`

## Requirements
- R1: After reset, the count reads 0x0000, the status register reads 0x0000 and `ovf_flag` is 0.
- R2: The input pin passes through a two-flop synchronizer. Each rising transition of the synchronized signal advances the count by exactly one. A level held high, or a falling transition, adds nothing.
- R3: With `wide_mode`=1, an edge at count 0xFFFF makes the count 0x0000 and sets the flag.
- R4: With `wide_mode`=0 and `sat_mode`=0, only bits 7:0 count. An edge at low byte 0xFF makes the low byte 0x00 and sets the flag, and bits 15:8 keep their value.
- R5: With `wide_mode`=0 and `sat_mode`=1, the low byte stops at 0xFF. An edge that arrives while the low byte is 0xFF leaves the count unchanged and sets the flag. Reaching 0xFF from 0xFE does not set the flag.
- R6: While `cnt_en`=0, edges change neither the count nor the flag.
- R7: Address 0 reads as the status register. The flag appears in bit 1 and every other bit reads 0. Reading this address never changes the flag.
- R8: With `fast_clr_en`=0, a write to address 0 with data bit 1 set clears the flag. A write with data bit 1 clear leaves the flag unchanged.
- R9: With `fast_clr_en`=1, writes to address 0 do not clear the flag. Instead, any read or write of address 1 clears the flag.
- R10: If a flag-setting edge and a clear request fall in the same cycle, the flag ends up set.
- R11: A write to address 1 loads all 16 bits of the count. If an edge falls in the same cycle, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Enables counting and flag setting |
| wide_mode | input | 1 | 1: 16-bit counter, 0: 8-bit counter on bits 7:0 |
| sat_mode | input | 1 | Holds the 8-bit count at 0xFF (8-bit mode only) |
| fast_clr_en | input | 1 | Selects clearing by count access instead of write-one-to-clear |
| edge_in | input | 1 | Asynchronous input pin whose rising edges are counted |
| sel | input | 1 | Bus access strobe |
| wr | input | 1 | 1: write, 0: read |
| addr | input | 1 | 0: status, 1: count |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero when `sel` is low |
| ovf_flag | output | 1 | Overflow flag |

## Verification
The bench drives single edge pulses in three situations:

- **Preloaded counts next to a wrap point** in each width. These separate a 16-bit rollover from an 8-bit one, and show whether the upper byte is left alone in 8-bit mode.
- **Counts just below and at 0xFF with the ceiling on.** These show whether the flag comes from arriving at the ceiling or from pressing against it.
- **Edges with the enable low.** These show that counting and flagging are both gated.

Clearing is tried as follows:

- Write-one-to-clear is tried with a data pattern that has the flag bit clear and one that has it set.
- Fast clear is tried with a status write, a count read and a count write.
- One edge is timed to land on a status write in the same cycle, which shows which of the two takes priority.

// File: rtl/pacc_ovf.sv
module pacc_ovf #(
  parameter int CNT_W    = 16,
  parameter int LO_W     = 8,
  parameter int FLAG_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             wide_mode,
  input  logic             sat_mode,
  input  logic             fast_clr_en,
  input  logic             edge_in,
  input  logic             sel,
  input  logic             wr,
  input  logic             addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             ovf_flag
);
  localparam int HI_W = CNT_W - LO_W;

  logic [2:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise, inc, cnt_wr, cnt_acc, stat_wr;
  logic             lo_max, full_max, hold, set_ev, clr;
  logic [LO_W-1:0]  lo_nxt;
  logic [CNT_W-1:0] flag_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], edge_in};

  assign rise     = sync_q[1] & ~sync_q[2];
  assign inc      = rise & cnt_en;
  assign cnt_acc  = sel & addr;
  assign cnt_wr   = cnt_acc & wr;
  assign stat_wr  = sel & wr & ~addr;

  assign lo_max   = &cnt_q[LO_W-1:0];
  assign full_max = &cnt_q;
  assign hold     = ~wide_mode & sat_mode & lo_max;
  assign set_ev   = inc & ~cnt_wr & (wide_mode ? full_max : lo_max);
  assign clr      = fast_clr_en ? cnt_acc : (stat_wr & wdata[FLAG_BIT]);
  assign lo_nxt   = cnt_q[LO_W-1:0] + {{(LO_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              cnt_q <= '0;
    else if (cnt_wr)         cnt_q <= wdata;
    else if (inc && !hold) begin
      if (wide_mode)         cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
      else                   cnt_q <= {cnt_q[CNT_W-1 -: HI_W], lo_nxt};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ovf_flag <= 1'b0;
    else if (set_ev) ovf_flag <= 1'b1;
    else if (clr)    ovf_flag <= 1'b0;

  always_comb begin
    flag_word           = '0;
    flag_word[FLAG_BIT] = ovf_flag;
  end

  assign rdata = !sel ? '0 : (addr ? cnt_q : flag_word);
endmodule

// File: rtl/pacc_ovf_chk.sv
module pacc_ovf_chk #(
  parameter int CNT_W    = 16,
  parameter int LO_W     = 8,
  parameter int FLAG_BIT = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             wide_mode,
  input logic             sat_mode,
  input logic             fast_clr_en,
  input logic             sel,
  input logic             wr,
  input logic             addr,
  input logic [CNT_W-1:0] wdata,
  input logic [CNT_W-1:0] rdata,
  input logic             ovf_flag,
  input logic             inc,
  input logic [CNT_W-1:0] cnt_q
);
  logic c_wr, s_wr;
  logic [CNT_W-1:0] other_mask;
  assign c_wr = sel & wr & addr;
  assign s_wr = sel & wr & ~addr;
  always_comb begin
    other_mask           = '1;
    other_mask[FLAG_BIT] = 1'b0;
  end

  a_r3_wrap16: assert property (@(posedge clk) disable iff (!rst_n)
    inc && wide_mode && (&cnt_q) && !c_wr |=> ovf_flag && cnt_q == '0);

  a_r4_wrap8: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !wide_mode && !sat_mode && (&cnt_q[LO_W-1:0]) && !c_wr
    |=> ovf_flag && cnt_q[LO_W-1:0] == '0
        && cnt_q[CNT_W-1:LO_W] == $past(cnt_q[CNT_W-1:LO_W]));

  a_r5_sat: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !wide_mode && sat_mode && (&cnt_q[LO_W-1:0]) && !c_wr
    |=> ovf_flag && $stable(cnt_q));

  a_r6_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en && !c_wr |=> $stable(cnt_q));

  a_r6_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en && !ovf_flag |=> !ovf_flag);

  a_r7_status: assert property (@(posedge clk) disable iff (!rst_n)
    sel && !addr |-> (rdata & other_mask) == '0 && rdata[FLAG_BIT] == ovf_flag);

  a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    s_wr && wdata[FLAG_BIT] && !fast_clr_en && !inc |=> !ovf_flag);

  a_r9_keep: assert property (@(posedge clk) disable iff (!rst_n)
    fast_clr_en && s_wr && ovf_flag |=> ovf_flag);

  a_r9_fast: assert property (@(posedge clk) disable iff (!rst_n)
    fast_clr_en && sel && addr && !inc |=> !ovf_flag);

  a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr |=> cnt_q == $past(wdata));
endmodule

bind pacc_ovf pacc_ovf_chk #(.CNT_W(CNT_W), .LO_W(LO_W), .FLAG_BIT(FLAG_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wide_mode(wide_mode),
  .sat_mode(sat_mode), .fast_clr_en(fast_clr_en), .sel(sel), .wr(wr),
  .addr(addr), .wdata(wdata), .rdata(rdata), .ovf_flag(ovf_flag),
  .inc(inc), .cnt_q(cnt_q)
);

// File: tb/pacc_ovf_tb.sv
module pacc_ovf_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cnt_en = 1'b1, wide_mode = 1'b1, sat_mode = 1'b0, fast_clr_en = 1'b0;
  logic edge_in = 1'b0, sel = 1'b0, wr = 1'b0, addr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ovf_flag;

  pacc_ovf u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wide_mode(wide_mode),
    .sat_mode(sat_mode), .fast_clr_en(fast_clr_en), .edge_in(edge_in),
    .sel(sel), .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ovf_flag(ovf_flag)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] m_cnt = '0;
  bit          m_flag = 0;

  task automatic model_edge();
    if (!cnt_en) return;
    if (wide_mode) begin
      if (m_cnt == 16'hFFFF) m_flag = 1;
      m_cnt = m_cnt + 16'd1;
    end else if (m_cnt[7:0] == 8'hFF) begin
      m_flag = 1;
      if (!sat_mode) m_cnt[7:0] = 8'h00;
    end else m_cnt[7:0] = m_cnt[7:0] + 8'd1;
  endtask

  task automatic pulse();
    @(posedge clk); #1 edge_in = 1'b1;
    repeat (3) @(posedge clk);
    #1 edge_in = 1'b0;
    repeat (3) @(posedge clk);
    model_edge();
  endtask

  task automatic bus_wr(input logic a, input logic [15:0] d);
    @(posedge clk); #1 sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 sel = 1'b0; wr = 1'b0;
    if (a) begin
      m_cnt = d;
      if (fast_clr_en) m_flag = 0;
    end else if (!fast_clr_en && d[1]) m_flag = 0;
  endtask

  task automatic bus_rd(input logic a, input string tag);
    exp_q.push_back(a ? m_cnt : {14'b0, m_flag, 1'b0});
    tag_q.push_back(tag);
    @(posedge clk); #1 sel = 1'b1; wr = 1'b0; addr = a;
    @(posedge clk); #1 sel = 1'b0;
    if (a && fast_clr_en) m_flag = 0;
  endtask

  task automatic chk_flag(input string tag);
    @(negedge clk);
    checks++;
    if (ovf_flag !== m_flag) begin
      fails++;
      $display("FAIL %s: ovf_flag actual %0b expected %0b", tag, ovf_flag, m_flag);
    end
  endtask

  always @(negedge clk) begin
    if (sel && !wr) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL monitor: read with no expected item, actual %h expected none", rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    bus_rd(0, "R1 status after reset");
    bus_rd(1, "R1 count after reset");
    chk_flag("R1 flag after reset");

    pulse(); pulse(); pulse();
    bus_rd(1, "R2 three edges counted once each");

    bus_wr(1, 16'hFFFE);
    bus_rd(1, "R11 count load");
    pulse();
    bus_rd(1, "R3 reach FFFF");
    bus_rd(0, "R3 no flag before wrap");
    pulse();
    bus_rd(1, "R3 wrap to 0000");
    bus_rd(0, "R3 flag after 16-bit wrap");
    chk_flag("R7 status read keeps flag");

    bus_wr(0, 16'hFFFD);
    bus_rd(0, "R8 write zero bit leaves flag");
    bus_wr(0, 16'h0002);
    bus_rd(0, "R8 write one clears flag");

    @(posedge clk); #1 wide_mode = 1'b0;
    bus_wr(1, 16'h12FE);
    pulse(); pulse();
    bus_rd(1, "R4 low byte wraps, high byte kept");
    bus_rd(0, "R4 flag after 8-bit wrap");
    bus_wr(0, 16'h0002);

    @(posedge clk); #1 sat_mode = 1'b1;
    bus_wr(1, 16'h00FD);
    pulse(); pulse();
    bus_rd(1, "R5 reach ceiling");
    bus_rd(0, "R5 no flag on reaching ceiling");
    pulse();
    bus_rd(1, "R5 held at ceiling");
    bus_rd(0, "R5 flag on edge at ceiling");
    bus_wr(0, 16'h0002);

    @(posedge clk); #1 cnt_en = 1'b0;
    pulse(); pulse();
    bus_rd(1, "R6 no count while disabled");
    bus_rd(0, "R6 no flag while disabled");
    @(posedge clk); #1 cnt_en = 1'b1;

    @(posedge clk); #1 fast_clr_en = 1'b1;
    pulse();
    bus_wr(0, 16'h0002);
    bus_rd(0, "R9 status write ignored in fast mode");
    bus_rd(1, "R9 count read");
    bus_rd(0, "R9 count read cleared flag");
    pulse();
    chk_flag("R9 flag set again");
    bus_wr(1, 16'h0010);
    bus_rd(0, "R9 count write cleared flag");
    bus_rd(1, "R11 count value after load");

    @(posedge clk); #1 fast_clr_en = 1'b0; sat_mode = 1'b0;
    bus_wr(1, 16'h00FF);
    pulse();
    bus_wr(1, 16'h00FF);
    @(posedge clk); #1 edge_in = 1'b1;
    repeat (2) @(posedge clk);
    #1 sel = 1'b1; wr = 1'b1; addr = 1'b0; wdata = 16'h0002;
    @(posedge clk); #1 sel = 1'b0; wr = 1'b0; edge_in = 1'b0;
    repeat (3) @(posedge clk);
    m_cnt = 16'h0000; m_flag = 1;
    bus_rd(0, "R10 set wins over clear");
    bus_rd(1, "R10 count wrapped");

    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule